// File: doc/BRIEF.md
# Parallel Flash Configuration Loader

This block is the configuration master that pulls a byte-wide image out of an external parallel NOR flash. A synchronous reset or a low pulse on the program input starts a fixed init phase. At the end of that phase the block latches the boot mode, the wait-state count and the image length. If the mode selects parallel-flash boot, it enables the flash and walks a 24-bit address, either upward from the bottom of memory or downward from the top. The other end of the flash stays free for a processor that shares it.

Each fetched byte goes out on a streaming port with a one-cycle valid strobe and the address it came from. When the programmed number of bytes has been read, the block raises done, deselects the flash and releases its bus-drive enable. A processor-hold output keeps the other bus master in reset until done is high, so only one master boots at a time.

Top module: `pflash_cfg_loader`

## Requirements
- R1: After a cycle with `rst_n` or `prog_n` sampled low, `init_o` is low for exactly 4 further clock edges and rises on the 4th.
- R2: `mode_i`, `wait_i` and `len_i` are sampled only on the clock edge where `init_o` rises. Changes after that edge have no effect until the next program request.
- R3: Parallel-flash boot is selected when `mode_i[2]`=0 and `mode_i[1]`=1. In any other mode, `flash_ce_n_o` and `flash_oe_n_o` stay 1, `flash_drive_o` stays 0, no byte is streamed and `done_o` stays 0.
- R4: With `mode_i[0]`=0, bytes are read from addresses 0x000000, 0x000001, and so on. With `mode_i[0]`=1, they are read from 0xFFFFFF, 0xFFFFFE, and so on.
- R5: With wait count W (1 to 15; 0 is treated as 1), each address is held for W clocks. Byte i (counting from 0) is captured W·(i+1) clocks after `init_o` rises.
- R6: Each captured byte appears on `strm_data_o`, with its source address on `strm_addr_o`, while `strm_valid_o` is high for the one cycle after the capture edge.
- R7: `flash_ce_n_o` and `flash_oe_n_o` are low and `flash_drive_o` is high from the edge where `init_o` rises until the edge where `done_o` rises. They are inactive at all other times.
- R8: `done_o` rises one clock after the last of `len_i` bytes is captured. It stays high until the next reset or program request.
- R9: A low `prog_n` aborts any load in progress. On the next edge `done_o` is cleared and the flash controls are inactive, and the sequence restarts from the init phase.
- R10: `cpu_hold_o` is high from reset or program request until `done_o` rises, and low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_n | input | 1 | Active-low program request (synchronous) |
| mode_i | input | 3 | Boot mode, sampled when init rises |
| wait_i | input | 4 | Wait states per byte, sampled when init rises |
| len_i | input | 8 | Image length in bytes, sampled when init rises |
| flash_data_i | input | 8 | Flash data bus |
| flash_addr_o | output | 24 | Flash address bus |
| flash_ce_n_o | output | 1 | Flash chip enable, active low |
| flash_oe_n_o | output | 1 | Flash output enable, active low |
| flash_drive_o | output | 1 | Bus-drive enable for address and controls |
| init_o | output | 1 | Init phase finished |
| done_o | output | 1 | Image fully read |
| cpu_hold_o | output | 1 | Holds the other bus master in reset |
| strm_valid_o | output | 1 | Byte-valid strobe |
| strm_data_o | output | 8 | Captured byte |
| strm_addr_o | output | 24 | Address of the captured byte |

## Verification
The bench sweeps all eight modes against several wait counts, including 0 and 15, and several image lengths. For every cycle of every load it predicts each output from the cycle index alone. A design that counts wait states off by one would shift every valid strobe. A design that used the wrong start value for the downward walk would stream 0x000000 first. A design that kept sampling the mode would follow the inputs, which the bench scrambles just after init rises, and change direction or length mid-load. A load is also aborted part-way through, so a design that let done or the flash enables survive a program request would fail the first cycle of the next run.

// File: rtl/pfl_pkg.sv
// Package: shared types and helpers for the parallel flash loader.
// Assumes: mode encoding is [2:0], flash boot selected by bits 2:1 = 2'b01.
package pfl_pkg;

    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_FINISH = 3'd2,
        ST_DONE   = 3'd3,
        ST_OTHER  = 3'd4
    } pfl_state_e;

    // True when the mode selects boot from parallel flash.
    function automatic logic is_flash_mode(input logic [2:0] m);
        return (m[2] == 1'b0) && (m[1] == 1'b1);
    endfunction

endpackage

// File: rtl/pfl_seq.sv
// Module: pfl_seq
// Sequencer for the flash loader: times the init phase, latches the
// configuration at init rise, counts wait states and bytes.
// Assumes: clr is synchronous and combines reset and program request.
module pfl_seq
    import pfl_pkg::*;
#(
    parameter int INIT_CYC = 4,
    parameter int WS_W     = 4,
    parameter int LEN_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [2:0]       mode_i,
    input  logic [WS_W-1:0]  wait_i,
    input  logic [LEN_W-1:0] len_i,
    output pfl_state_e       state_o,
    output logic             start_o,
    output logic             step_o
);
    localparam int IC_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
    localparam logic [IC_W-1:0]  IC_LAST = IC_W'(INIT_CYC - 1);
    localparam logic [WS_W-1:0]  WS_ONE  = WS_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    pfl_state_e       state;
    logic [IC_W-1:0]  icnt;
    logic [WS_W-1:0]  ws;
    logic [WS_W-1:0]  wait_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] bcnt;

    // Start pulse at the end of the init phase; step when waits expire.
    always_comb begin
        start_o = (state == ST_INIT) && (icnt == IC_LAST);
        step_o  = (state == ST_FETCH) && (ws == wait_q);
        state_o = state;
    end

    // Main sequencing: init timing, config latch, wait and byte counting.
    always_ff @(posedge clk) begin
        if (clr) begin
            state  <= ST_INIT;
            icnt   <= '0;
            ws     <= WS_ONE;
            bcnt   <= '0;
            wait_q <= WS_ONE;
            len_q  <= LEN_ONE;
        end else begin
            case (state)
                ST_INIT: begin
                    if (icnt == IC_LAST) begin
                        wait_q <= (wait_i == '0) ? WS_ONE : wait_i;
                        len_q  <= len_i;
                        ws     <= WS_ONE;
                        bcnt   <= '0;
                        state  <= is_flash_mode(mode_i) ? ST_FETCH : ST_OTHER;
                    end else begin
                        icnt <= icnt + IC_W'(1);
                    end
                end
                ST_FETCH: begin
                    if (ws == wait_q) begin
                        ws   <= WS_ONE;
                        bcnt <= bcnt + LEN_ONE;
                        if (bcnt == len_q - LEN_ONE) state <= ST_FINISH;
                    end else begin
                        ws <= ws + WS_ONE;
                    end
                end
                ST_FINISH: state <= ST_DONE;
                default:   state <= state;
            endcase
        end
    end

    // R5: the wait counter stays inside 1..W while fetching.
    a_r5_ws_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> (ws >= WS_ONE && ws <= wait_q));

    // R2: latched configuration does not move once fetching has begun.
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_FETCH && $past(state == ST_FETCH)) |-> ($stable(wait_q) && $stable(len_q)));

endmodule

// File: rtl/pfl_addr_gen.sv
// Module: pfl_addr_gen
// Flash address walker: loads bottom or top of memory on start, then
// moves one step up or down per captured byte.
// Assumes: load and step are never high in the same cycle.
module pfl_addr_gen #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              down_in,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] addr;
    logic              down_q;

    assign addr_o = addr;

    // Address register: start value on load, unit step on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            addr   <= down_in ? '1 : '0;
            down_q <= down_in;
        end else if (step) begin
            addr <= down_q ? addr - ADDR_ONE : addr + ADDR_ONE;
        end
    end

    // R4: each step moves the address by exactly one in the latched direction.
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr_o == ($past(down_q) ? $past(addr_o) - ADDR_ONE
                                                      : $past(addr_o) + ADDR_ONE)));

endmodule

// File: rtl/pfl_capture.sv
// Module: pfl_capture
// Output stage: registers the flash byte and its address on each step
// and raises a one-cycle valid strobe.
// Assumes: flash data is settled at the step edge.
module pfl_capture #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              step,
    input  logic [DATA_W-1:0] data_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] addr_o
);
    // Byte capture and strobe generation.
    always_ff @(posedge clk) begin
        if (clr) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            addr_o  <= '0;
        end else begin
            valid_o <= step;
            if (step) begin
                data_o <= data_in;
                addr_o <= addr_in;
            end
        end
    end

    // R6: a capture leaves the source address on the stream port.
    a_r6_addr_tag: assert property (@(posedge clk) disable iff (clr)
        step |=> (valid_o && addr_o == $past(addr_in)));

endmodule

// File: rtl/pflash_cfg_loader.sv
// Module: pflash_cfg_loader (top)
// Parallel NOR flash configuration master: init phase, mode latch,
// directional byte fetch with wait states, done and processor hold.
// Assumes: rst_n and prog_n are synchronous to clk.
module pflash_cfg_loader
    import pfl_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 8,
    parameter int WS_W     = 4,
    parameter int LEN_W    = 8,
    parameter int INIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic [2:0]        mode_i,
    input  logic [WS_W-1:0]   wait_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] flash_data_i,
    output logic [ADDR_W-1:0] flash_addr_o,
    output logic              flash_ce_n_o,
    output logic              flash_oe_n_o,
    output logic              flash_drive_o,
    output logic              init_o,
    output logic              done_o,
    output logic              cpu_hold_o,
    output logic              strm_valid_o,
    output logic [DATA_W-1:0] strm_data_o,
    output logic [ADDR_W-1:0] strm_addr_o
);
    pfl_state_e state;
    logic       clr;
    logic       start;
    logic       step;
    logic       active;

    assign clr = !rst_n || !prog_n;

    pfl_seq #(
        .INIT_CYC(INIT_CYC),
        .WS_W    (WS_W),
        .LEN_W   (LEN_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .mode_i (mode_i),
        .wait_i (wait_i),
        .len_i  (len_i),
        .state_o(state),
        .start_o(start),
        .step_o (step)
    );

    pfl_addr_gen #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .down_in(mode_i[0]),
        .step   (step),
        .addr_o (flash_addr_o)
    );

    pfl_capture #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_cap (
        .clk    (clk),
        .clr    (clr),
        .step   (step),
        .data_in(flash_data_i),
        .addr_in(flash_addr_o),
        .valid_o(strm_valid_o),
        .data_o (strm_data_o),
        .addr_o (strm_addr_o)
    );

    // Output decode from the sequencer state.
    always_comb begin
        active        = (state == ST_FETCH) || (state == ST_FINISH);
        flash_ce_n_o  = !active;
        flash_oe_n_o  = !active;
        flash_drive_o = active;
        init_o        = (state != ST_INIT);
        done_o        = (state == ST_DONE);
        cpu_hold_o    = !done_o;
    end

    // R7: once done, the flash is deselected and the bus released.
    a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flash_ce_n_o && flash_oe_n_o && !flash_drive_o));

    // R8: done rises only the clock after a byte was streamed.
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(strm_valid_o));

    // R9: a program request clears done and restarts init.
    a_r9_prog_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> (!done_o && !init_o && flash_ce_n_o));

    // R1: init rises only after four clocks low.
    a_r1_init_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_o) |-> ($past(!init_o, 1) && $past(!init_o, 4)));

endmodule

// File: tb/sim_pflash_cfg_loader.sv
module sim_pflash_cfg_loader;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_n;
    logic [2:0]  mode_i;
    logic [3:0]  wait_i;
    logic [7:0]  len_i;
    logic [7:0]  flash_data_i;
    logic [23:0] flash_addr_o;
    logic        flash_ce_n_o, flash_oe_n_o, flash_drive_o;
    logic        init_o, done_o, cpu_hold_o, strm_valid_o;
    logic [7:0]  strm_data_o;
    logic [23:0] strm_addr_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    pflash_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_i(mode_i),
        .wait_i(wait_i), .len_i(len_i), .flash_data_i(flash_data_i),
        .flash_addr_o(flash_addr_o), .flash_ce_n_o(flash_ce_n_o),
        .flash_oe_n_o(flash_oe_n_o), .flash_drive_o(flash_drive_o),
        .init_o(init_o), .done_o(done_o), .cpu_hold_o(cpu_hold_o),
        .strm_valid_o(strm_valid_o), .strm_data_o(strm_data_o),
        .strm_addr_o(strm_addr_o)
    );

    function automatic logic [7:0] fmodel(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign flash_data_i = fmodel(flash_addr_o);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // One load: program pulse, then per-cycle comparison against the model.
    task automatic run_load(input logic [2:0] m, input int w, input int l, input int abort_at);
        bit flash;
        int we, total;
        @(negedge clk);
        mode_i = m; wait_i = 4'(w); len_i = 8'(l); prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        flash = (m[2] == 1'b0) && (m[1] == 1'b1);
        we    = (w == 0) ? 1 : w;
        total = 4 + we * l;
        for (int k = 0; k < total + 4; k++) begin
            bit exp_init, exp_done, exp_act, exp_val;
            if (abort_at >= 0 && k == abort_at) return;
            exp_init = (k >= 4);
            exp_done = flash && (k >= total + 1);
            exp_act  = flash && (k >= 4) && (k <= total);
            exp_val  = flash && (k > 4) && (((k - 4) % we) == 0) && (((k - 4) / we) <= l);
            chk(init_o == exp_init, "R1 init", 32'(init_o), 32'(exp_init));
            chk(done_o == exp_done, flash ? "R8 done" : "R3 done", 32'(done_o), 32'(exp_done));
            chk(flash_ce_n_o == !exp_act, flash ? "R7 ce_n" : "R3 ce_n",
                32'(flash_ce_n_o), 32'(!exp_act));
            chk(flash_oe_n_o == !exp_act, flash ? "R7 oe_n" : "R3 oe_n",
                32'(flash_oe_n_o), 32'(!exp_act));
            chk(flash_drive_o == exp_act, flash ? "R7 drive" : "R3 drive",
                32'(flash_drive_o), 32'(exp_act));
            chk(cpu_hold_o == !exp_done, "R10 hold", 32'(cpu_hold_o), 32'(!exp_done));
            chk(strm_valid_o == exp_val, flash ? "R5 valid timing" : "R3 valid",
                32'(strm_valid_o), 32'(exp_val));
            if (exp_val) begin
                int idx;
                logic [23:0] ea;
                idx = (k - 4) / we - 1;
                ea  = m[0] ? (24'hFFFFFF - 24'(idx)) : 24'(idx);
                chk(strm_addr_o == ea, "R4 address order", 32'(strm_addr_o), 32'(ea));
                chk(strm_data_o == fmodel(ea), "R6 data", 32'(strm_data_o), 32'(fmodel(ea)));
            end
            // R2: scramble the configuration after it has been latched.
            if (k == 5) begin
                mode_i = ~m; wait_i = ~4'(w); len_i = ~8'(l);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int wl[5] = '{0, 1, 2, 3, 15};
        int ll[3] = '{1, 2, 5};
        rst_n = 1'b0; prog_n = 1'b1; mode_i = 3'b010; wait_i = 4'd1; len_i = 8'd1;
        repeat (3) @(negedge clk);
        // Reset state (R1, R7, R8, R10).
        chk(init_o == 1'b0, "R1 reset init", 32'(init_o), 32'd0);
        chk(done_o == 1'b0, "R8 reset done", 32'(done_o), 32'd0);
        chk(flash_ce_n_o == 1'b1, "R7 reset ce_n", 32'(flash_ce_n_o), 32'd1);
        chk(cpu_hold_o == 1'b1, "R10 reset hold", 32'(cpu_hold_o), 32'd1);
        rst_n = 1'b1;
        // R3, R4, R5: sweep modes, wait counts and lengths.
        for (int m = 0; m < 8; m++)
            for (int wi = 0; wi < 5; wi++)
                for (int li = 0; li < 3; li++)
                    run_load(3'(m), wl[wi], ll[li], -1);
        // R9: abort mid-fetch and after done, then reload cleanly.
        run_load(3'b010, 3, 5, 9);
        run_load(3'b011, 2, 5, -1);
        run_load(3'b011, 2, 2, 3);
        run_load(3'b010, 1, 5, -1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule